// File: doc/BRIEF.md
# Device Interrupt Pin Route Table

This block holds one 16-bit route word for each device slot in a window of seven consecutive slot numbers (25 to 31). A route word packs four 4-bit fields, one per INTx pin, and each field names one of eight shared interrupt lines (0 to 7, lines A to H). A combinational lookup port takes a slot number and a pin and returns the line that pin drives. Software reaches the words through a small byte-addressed register window. The access port carries a valid strobe, a write flag, an address, a byte length of up to four and little-endian data.

Slot 30 is special. Its route word is read-only zero, and its pins A to D always drive lines 4 to 7. Every slot outside the routed window follows a rotating default that uses only lines 4 to 7. This leaves lines 0 to 3 free for other sources. Any write pulses a one-cycle routing-changed output, so logic downstream can re-evaluate its own routing.

Register layout (byte offsets in the 32-byte window):

- The route word for slot s sits at offset 2·(s − 25), low byte first.
- Offsets 0x0A and 0x0B belong to slot 30 and are read-only zero.
- A 32-bit general control word sits at offset 0x10.
- All other bytes are plain storage that resets to zero.

Top module: `pin_route_table`

## Requirements
- R1: A synchronous reset clears every byte to zero. It then loads 0x3210 into each writable route word (slots 25 to 29 and 31) and 0x00000021 into the control word at offset 0x10. It also drives `rd_valid` and `route_changed` low.
- R2: For a slot from 25 to 31 other than 30, pin p (0 = A … 3 = D) drives the line given by bits [4p+2:4p] of that slot's route word. Bit 4p+3 is ignored.
- R3: The slot 30 word (offsets 0x0A and 0x0B) always reads zero, and writes to it are ignored. Slot 30 pin p always drives line 4 + p.
- R4: For any slot below 25, pin p drives line ((slot + p) mod 4) + 4.
- R5: A write changes the lookup result starting in the cycle after the write is accepted.
- R6: `route_changed` is high for exactly the one cycle after each accepted write, including writes to read-only bytes. Reads never raise it.
- R7: Accesses are little-endian: request byte lane k (data bits [8k+7:8k]) maps to byte offset addr + k.
- R8: A length above 4 is treated as 4. If offset + length reaches past the 32-byte window, the length is cut so the access ends at byte 31. No byte wraps to offset 0.
- R9: Only the low 5 address bits select a byte; the upper request address bits are ignored.
- R10: A read returns its data with `rd_valid` high in the cycle after the request. Byte lanes at or beyond the clipped length read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Access request strobe |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 16 | Byte address (masked to the window) |
| req_len | input | 3 | Byte count, 0 to 4 (larger values act as 4) |
| req_wdata | input | 32 | Write data, little-endian lanes |
| rd_valid | output | 1 | Read data valid, one cycle after a read |
| rd_data | output | 32 | Read data, unused lanes zero |
| route_changed | output | 1 | One-cycle pulse after each write |
| lk_slot | input | 5 | Lookup slot number |
| lk_pin | input | 2 | Lookup pin, 0 = A … 3 = D |
| lk_line | output | 3 | Shared interrupt line for slot and pin |

## Verification
The assertions check four properties on every cycle:

- The one-cycle timing of `route_changed` and `rd_valid` against the requests that cause them.
- The fixed line mapping of slot 30.
- The rule that default slots never select a line below 4.
- The zeroing of the upper lanes for one-byte reads.

Only the bench's scenarios can show the rest, because each depends on the history of writes:

- The stored reset defaults.
- The decoding of pin fields after writes.
- The little-endian lane order.
- Clipping at the window's end.
- Address masking.
- The read-only behaviour of the slot 30 word.

// File: rtl/pin_route_pkg.sv
package pin_route_pkg;
  localparam int FIRST_SLOT = 25;
  localparam int NUM_ROUTED = 7;
  localparam int FIXED_SLOT = 30;
  localparam int PINS       = 4;
  localparam int FIELD_W    = 4;
  localparam int LINE_W     = 3;
  localparam int SLOT_W     = 5;
  localparam int PIN_W      = 2;
  localparam int WORD_W     = 16;
  localparam int HI_BANK    = 4;
  typedef logic [LINE_W-1:0] line_t;
endpackage

// File: rtl/pin_route_clip.sv
module pin_route_clip #(
  parameter int BLK_BYTES = 32,
  parameter int ADDR_W    = 5,
  parameter int LANES     = 4,
  parameter int LEN_W     = 3,
  parameter int CNT_W     = 3
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [LEN_W-1:0]  len,
  output logic [CNT_W-1:0]  clen
);
  int eff;
  always_comb begin
    eff = (int'(len) > LANES) ? LANES : int'(len);
    if (int'(addr) + eff >= BLK_BYTES)
      eff = BLK_BYTES - int'(addr);
    clen = CNT_W'(eff);
  end
endmodule

// File: rtl/pin_route_store.sv
module pin_route_store
  import pin_route_pkg::*;
#(
  parameter int          BLK_BYTES     = 32,
  parameter int          ADDR_W        = 5,
  parameter int          LANES         = 4,
  parameter int          CNT_W         = 3,
  parameter int          CTRL_OFF      = 16,
  parameter logic [15:0] ROUTE_DEFAULT = 16'h3210,
  parameter logic [31:0] CTRL_DEFAULT  = 32'h0000_0021
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   wr_en,
  input  logic [ADDR_W-1:0]      addr,
  input  logic [CNT_W-1:0]       clen,
  input  logic [8*LANES-1:0]     wdata,
  output logic [8*BLK_BYTES-1:0] mem_flat
);
  localparam int LSEL_W   = $clog2(LANES);
  localparam int RO_BYTE0 = 2 * (FIXED_SLOT - FIRST_SLOT);

  for (genvar i = 0; i < BLK_BYTES; i++) begin : g_byte
    localparam bit IS_RO    = (i == RO_BYTE0) || (i == RO_BYTE0 + 1);
    localparam bit IS_ROUTE = (i < 2 * NUM_ROUTED) && !IS_RO;
    localparam bit IS_CTRL  = (i >= CTRL_OFF) && (i < CTRL_OFF + 4);
    localparam logic [7:0] RST_V =
      IS_ROUTE ? ROUTE_DEFAULT[8*(i%2) +: 8] :
      IS_CTRL  ? CTRL_DEFAULT[8*((i-CTRL_OFF)%4) +: 8] : 8'h00;

    if (IS_RO) begin : g_ro
      assign mem_flat[8*i +: 8] = 8'h00;
    end else begin : g_rw
      logic [ADDR_W:0] lane;
      logic            hit;
      logic [7:0]      q;
      always_comb begin
        lane = (ADDR_W+1)'(i) - {1'b0, addr};
        hit  = wr_en && ({1'b0, addr} <= (ADDR_W+1)'(i)) &&
               (lane < (ADDR_W+1)'(clen));
      end
      always_ff @(posedge clk) begin
        if (rst)
          q <= RST_V;
        else if (hit)
          q <= wdata[{lane[LSEL_W-1:0], 3'b000} +: 8];
      end
      assign mem_flat[8*i +: 8] = q;
    end
  end
endmodule

// File: rtl/pin_route_decode.sv
module pin_route_decode
  import pin_route_pkg::*;
(
  input  logic [NUM_ROUTED*WORD_W-1:0] words,
  input  logic [SLOT_W-1:0]            slot,
  input  logic [PIN_W-1:0]             pin,
  output line_t                        line
);
  logic [WORD_W-1:0] word;
  always_comb begin
    word = '0;
    if (int'(slot) == FIXED_SLOT) begin
      line = LINE_W'(HI_BANK + int'(pin));
    end else if (int'(slot) >= FIRST_SLOT && int'(slot) < FIRST_SLOT + NUM_ROUTED) begin
      word = words[(int'(slot) - FIRST_SLOT) * WORD_W +: WORD_W];
      line = word[int'(pin) * FIELD_W +: LINE_W];
    end else begin
      line = LINE_W'(HI_BANK + ((int'(slot) + int'(pin)) % PINS));
    end
  end
endmodule

// File: rtl/pin_route_table.sv
module pin_route_table
  import pin_route_pkg::*;
#(
  parameter int          BLK_BYTES     = 32,
  parameter int          ADDR_IN_W     = 16,
  parameter int          LANES         = 4,
  parameter int          LEN_W         = 3,
  parameter int          CTRL_OFF      = 16,
  parameter logic [15:0] ROUTE_DEFAULT = 16'h3210,
  parameter logic [31:0] CTRL_DEFAULT  = 32'h0000_0021
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 req_valid,
  input  logic                 req_write,
  input  logic [ADDR_IN_W-1:0] req_addr,
  input  logic [LEN_W-1:0]     req_len,
  input  logic [8*LANES-1:0]   req_wdata,
  output logic                 rd_valid,
  output logic [8*LANES-1:0]   rd_data,
  output logic                 route_changed,
  input  logic [4:0]           lk_slot,
  input  logic [1:0]           lk_pin,
  output logic [2:0]           lk_line
);
  localparam int ADDR_W = $clog2(BLK_BYTES);
  localparam int CNT_W  = $clog2(LANES + 1);

  logic [ADDR_W-1:0]      addr;
  logic [CNT_W-1:0]       clen;
  logic [8*BLK_BYTES-1:0] mem_flat;
  logic [8*LANES-1:0]     rd_next;
  logic                   wr_en;
  logic                   unused_addr_hi;

  assign addr           = req_addr[ADDR_W-1:0];
  assign unused_addr_hi = ^req_addr[ADDR_IN_W-1:ADDR_W];
  assign wr_en          = req_valid && req_write;

  pin_route_clip #(
    .BLK_BYTES(BLK_BYTES), .ADDR_W(ADDR_W), .LANES(LANES),
    .LEN_W(LEN_W), .CNT_W(CNT_W)
  ) clip_i (
    .addr(addr), .len(req_len), .clen(clen)
  );

  pin_route_store #(
    .BLK_BYTES(BLK_BYTES), .ADDR_W(ADDR_W), .LANES(LANES), .CNT_W(CNT_W),
    .CTRL_OFF(CTRL_OFF), .ROUTE_DEFAULT(ROUTE_DEFAULT), .CTRL_DEFAULT(CTRL_DEFAULT)
  ) store_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .clen(clen),
    .wdata(req_wdata), .mem_flat(mem_flat)
  );

  pin_route_decode decode_i (
    .words(mem_flat[NUM_ROUTED*WORD_W-1:0]),
    .slot(lk_slot), .pin(lk_pin), .line(lk_line)
  );

  for (genvar k = 0; k < LANES; k++) begin : g_rlane
    logic [ADDR_W-1:0] idx;
    assign idx = addr + ADDR_W'(k);
    assign rd_next[8*k +: 8] = (CNT_W'(k) < clen) ? mem_flat[{idx, 3'b000} +: 8] : 8'h00;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_valid      <= 1'b0;
      rd_data       <= '0;
      route_changed <= 1'b0;
    end else begin
      rd_valid      <= req_valid && !req_write;
      route_changed <= wr_en;
      if (req_valid && !req_write)
        rd_data <= rd_next;
    end
  end
endmodule

// File: rtl/pin_route_table_chk.sv
module pin_route_table_chk #(
  parameter int ADDR_IN_W = 16,
  parameter int LANES     = 4,
  parameter int LEN_W     = 3
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 req_valid,
  input logic                 req_write,
  input logic [ADDR_IN_W-1:0] req_addr,
  input logic [LEN_W-1:0]     req_len,
  input logic [8*LANES-1:0]   req_wdata,
  input logic                 rd_valid,
  input logic [8*LANES-1:0]   rd_data,
  input logic                 route_changed,
  input logic [4:0]           lk_slot,
  input logic [1:0]           lk_pin,
  input logic [2:0]           lk_line
);
  p_wr_pulse_r6: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_write) |=> route_changed);
  p_no_spurious_pulse_r6: assert property (@(posedge clk) disable iff (rst)
    !(req_valid && req_write) |=> !route_changed);
  p_rd_valid_r10: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !req_write) |=> rd_valid);
  p_rd_idle_r10: assert property (@(posedge clk) disable iff (rst)
    !(req_valid && !req_write) |=> !rd_valid);
  p_one_byte_lanes_r10: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !req_write && req_len == 3'd1) |=> (rd_data[8*LANES-1:8] == '0));
  p_fixed_slot_r3: assert property (@(posedge clk) disable iff (rst)
    (lk_slot == 5'd30) |-> (lk_line == 3'(4 + int'(lk_pin))));
  p_default_bank_r4: assert property (@(posedge clk) disable iff (rst)
    (lk_slot < 5'd25) |-> lk_line[2]);
endmodule

bind pin_route_table pin_route_table_chk chk_i (.*);

// File: tb/pin_route_table_tb_top.sv
`timescale 1ns/1ps
module pin_route_table_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [15:0] req_addr = '0;
  logic [2:0]  req_len = '0;
  logic [31:0] req_wdata = '0;
  logic        rd_valid, route_changed;
  logic [31:0] rd_data;
  logic [4:0]  lk_slot = '0;
  logic [1:0]  lk_pin = '0;
  logic [2:0]  lk_line;

  int checks = 0, fails = 0;
  bit done = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #2 clk = ~clk;

  pin_route_table dut_i (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_len(req_len), .req_wdata(req_wdata),
    .rd_valid(rd_valid), .rd_data(rd_data), .route_changed(route_changed),
    .lk_slot(lk_slot), .lk_pin(lk_pin), .lk_line(lk_line)
  );

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [15:0] a, input logic [2:0] l, input logic [31:0] d);
    @(negedge clk);
    req_valid = 1; req_write = 1; req_addr = a; req_len = l; req_wdata = d;
    @(negedge clk);
    req_valid = 0; req_write = 0;
    check(route_changed == 1'b1, "R6 pulse after write", 32'(route_changed), 32'd1);
  endtask

  task automatic rd(input logic [15:0] a, input logic [2:0] l, input logic [31:0] exp, input string tag);
    @(negedge clk);
    req_valid = 1; req_write = 0; req_addr = a; req_len = l;
    exp_q.push_back(exp); tag_q.push_back(tag);
    @(negedge clk);
    req_valid = 0;
  endtask

  task automatic lk(input logic [4:0] s, input logic [1:0] p, input logic [2:0] exp, input string tag);
    @(negedge clk);
    lk_slot = s; lk_pin = p;
    #1;
    check(lk_line == exp, tag, 32'(lk_line), 32'(exp));
  endtask

  // Monitor: pops expected read data from the scoreboard queue
  always @(negedge clk) begin
    if (!rst && rd_valid) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R10 unexpected rd_valid", 32'd1, 32'd0);
      end else begin
        logic [31:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(rd_data == e, t, rd_data, e);
      end
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 4);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    check(rd_valid == 0 && route_changed == 0, "R1 outputs low after reset",
          {30'd0, rd_valid, route_changed}, 32'd0);
    // R1 reset contents
    rd(16'h0000, 3'd4, 32'h3210_3210, "R1 slots 25/26 default");
    rd(16'h0008, 3'd4, 32'h0000_3210, "R1 slot 29 default, slot 30 zero");
    rd(16'h000C, 3'd4, 32'h0000_3210, "R1 slot 31 default");
    rd(16'h0010, 3'd4, 32'h0000_0021, "R1 control default");
    rd(16'h0014, 3'd4, 32'h0000_0000, "R1 other bytes zero");
    @(negedge clk);
    check(route_changed == 0, "R6 no pulse on read", 32'(route_changed), 32'd0);
    // R2 default decode, R3, R4
    lk(5'd25, 2'd0, 3'd0, "R2 slot25 pinA default");
    lk(5'd31, 2'd3, 3'd3, "R2 slot31 pinD default");
    lk(5'd30, 2'd2, 3'd6, "R3 slot30 pinC");
    lk(5'd3,  2'd2, 3'd5, "R4 slot3 pinC rotating");
    lk(5'd0,  2'd0, 3'd4, "R4 slot0 pinA rotating");
    lk(5'd24, 2'd3, 3'd7, "R4 slot24 pinD rotating");
    // R5/R7 write slot 27 word
    wr(16'h0004, 3'd2, 32'h0000_0765);
    lk(5'd27, 2'd0, 3'd5, "R5 slot27 pinA after write");
    lk(5'd27, 2'd1, 3'd6, "R2 slot27 pinB");
    lk(5'd27, 2'd2, 3'd7, "R2 slot27 pinC");
    lk(5'd27, 2'd3, 3'd0, "R2 slot27 pinD");
    rd(16'h0004, 3'd2, 32'h0000_0765, "R7 slot27 readback");
    // R2 top field bit ignored
    wr(16'h0006, 3'd2, 32'h0000_FEDC);
    lk(5'd28, 2'd0, 3'd4, "R2 slot28 pinA high bit ignored");
    lk(5'd28, 2'd3, 3'd7, "R2 slot28 pinD high bit ignored");
    // R7 spanning write
    wr(16'h0000, 3'd4, 32'h1234_5678);
    lk(5'd25, 2'd0, 3'd0, "R7 slot25 pinA from byte0");
    lk(5'd25, 2'd1, 3'd7, "R7 slot25 pinB");
    lk(5'd26, 2'd3, 3'd1, "R7 slot26 pinD from byte3");
    rd(16'h0001, 3'd2, 32'h0000_3456, "R7 unaligned read");
    // R3 read-only word
    wr(16'h000A, 3'd2, 32'h0000_FFFF);
    rd(16'h000A, 3'd2, 32'h0000_0000, "R3 slot30 word reads zero");
    lk(5'd30, 2'd1, 3'd5, "R3 slot30 pinB after write");
    // R8 clipping
    wr(16'h001E, 3'd4, 32'hAABB_CCDD);
    rd(16'h001E, 3'd4, 32'h0000_CCDD, "R8 clipped read at end");
    rd(16'h001C, 3'd4, 32'hCCDD_0000, "R8 clipped write landed");
    rd(16'h0000, 3'd1, 32'h0000_0078, "R8 no wrap to offset 0");
    rd(16'h0010, 3'd7, 32'h0000_0021, "R8 length above 4 acts as 4");
    // R9 masking
    rd(16'h0124, 3'd2, 32'h0000_0765, "R9 high address bits ignored on read");
    wr(16'h8010, 3'd1, 32'h0000_005A);
    rd(16'h0010, 3'd4, 32'h0000_005A, "R9 masked write to control");
    // R10 lanes beyond length
    rd(16'h000C, 3'd3, 32'h0000_3210, "R10 three-byte read lane3 zero");
    rd(16'h0008, 3'd1, 32'h0000_0010, "R10 one-byte read");
    @(negedge clk);
    check(route_changed == 0, "R6 pulse lasts one cycle", 32'(route_changed), 32'd0);
    // R1 reset again restores defaults
    @(negedge clk); rst = 1;
    @(negedge clk); rst = 0;
    rd(16'h0004, 3'd2, 32'h0000_3210, "R1 reset restores slot27");
    lk(5'd27, 2'd0, 3'd0, "R1 lookup after reset");
    repeat (3) @(negedge clk);
    check(exp_q.size() == 0, "R10 all reads returned", exp_q.size(), 32'd0);
    finish_run();
  end
endmodule